// File: doc/BRIEF.md
# SDRAM Bank Configuration Register Unit

This block is the register and address-decode front end of a four-bank SDRAM controller. Software reaches it through a pair of bus registers: a pointer register that selects a sub-register by its offset, and a data register through which the selected sub-register is read or written. The sub-registers hold two error status words, an error address, the global configuration, a read-only status word, refresh and power-management settings, a timing word, ECC configuration and ECC error status, and one configuration word per bank.

Each bank word describes a window in the system address space: an enable bit, a base aligned to 8 MiB, and a 3-bit size code. The block compares an incoming system address against the four windows and returns a one-hot hit vector and the offset of the address inside the window that hit. Decoding is gated by a global enable bit in the configuration word. The block also raises an ECC interrupt whenever the ECC error status holds a nonzero value, and it takes error pulses and an error address from the memory side.

Top module: `sdram_cfg_unit`

## Requirements
- R1: With busSel low, busRdata returns the pointer register. A write with busSel low loads it with busWdata. It resets to 0.
- R2: After reset the sub-registers read: both error status words 0, error address 0, configuration 0x00800000, status 0, refresh 0x05F00000, power-management 0x07C00000, all four bank words 0, ECC configuration 0, ECC error status 0.
- R3: Offsets 0x00 and 0x08 are error status 0 and 1, 0x10 is error address, 0x20 configuration, 0x24 status, 0x30 refresh, 0x34 power-management, 0x40 + 4·n bank n (n = 0..3), 0x80 timing, 0x94 ECC configuration and 0x98 ECC error status. Timing and every other offset read 0xFFFFFFFF. Writes to status or to an unknown offset change no register.
- R4: Written values are stored masked: configuration with 0xFFE00000, refresh with 0x3FF80000, ECC configuration with 0x00F00000, ECC error status with 0xFFF0F000.
- R5: A power-management write stores (value AND 0xF8000000) OR 0x07C00000.
- R6: An error status bit is set by a pulse on its hardware error input and cleared by writing 1 to it. When a pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: The error address loads errAddrIn when errAddrLoad is high and loads busWdata on a bus write. When both occur in the same cycle, the hardware value is kept.
- R8: When configuration bit 31 changes from 0 to 1, status bit 31 is cleared. When it changes from 1 to 0, status bit 31 is set. A write that leaves bit 31 unchanged leaves status bit 31 unchanged.
- R9: Status bit 30 equals configuration bit 30 after every configuration write.
- R10: A bank word stores the written value AND 0xFFDEE001.
- R11: Bank n covers the addresses from base to base + (4 MiB << code) − 1, where base is bits 31:23 of the bank word followed by 23 zero bits, and code is bits 19:17. Code 7 never matches. On a hit, bankOffset is the address minus the base.
- R12: A bank hits only if configuration bit 31 and bit 0 of its bank word are both set. With no hit, bankHit and bankOffset are 0.
- R13: When windows overlap, only the lowest-numbered matching bank is reported.
- R14: eccIrq is high exactly while the stored ECC error status is nonzero. It rises the cycle after a write that stores a nonzero value and falls the cycle after a write that stores zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | 0 selects the pointer register, 1 selects the data register |
| busWe | input | 1 | Write strobe for the selected bus register |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Bus read data (combinational) |
| errPulse0 | input | 32 | Hardware set pulses for error status 0 |
| errPulse1 | input | 32 | Hardware set pulses for error status 1 |
| errAddrLoad | input | 1 | Loads the error address from errAddrIn |
| errAddrIn | input | 32 | Address of the failing access |
| sysAddr | input | 32 | System address to decode |
| bankHit | output | 4 | One-hot bank hit vector |
| bankOffset | output | 32 | Address minus the hit bank's base |
| eccIrq | output | 1 | ECC error interrupt |

## Verification
On every cycle the assertions check that the hit vector is one-hot or zero, that no bank hits while the controller is disabled and that a miss gives a zero offset. They also check that at most one write strobe fires, that the forced power-management field stays set, that a hardware error pulse is always captured, that status bit 31 moves opposite to configuration bit 31, and that a write storing zero into ECC error status drops the interrupt. Only the bench scenarios show the actual values: the masked contents of each register, the window edges for every size code, the priority when windows overlap, and the outcome when a clear and a set meet in one cycle.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
  localparam int REG_W         = 32;
  localparam int NUM_BANKS     = 4;
  localparam int BASE_LSB      = 23;
  localparam int BASE_W        = REG_W - BASE_LSB;
  localparam int CODE_LSB      = 17;
  localparam int CODE_W        = 3;
  localparam int MIN_SPAN_LOG2 = 22;
  localparam int BANK_STRIDE   = 4;
  localparam logic [CODE_W-1:0] INVALID_CODE = '1;

  localparam logic [REG_W-1:0] OFS_ESR0   = 32'h00;
  localparam logic [REG_W-1:0] OFS_ESR1   = 32'h08;
  localparam logic [REG_W-1:0] OFS_EADDR  = 32'h10;
  localparam logic [REG_W-1:0] OFS_CFG    = 32'h20;
  localparam logic [REG_W-1:0] OFS_STAT   = 32'h24;
  localparam logic [REG_W-1:0] OFS_RFR    = 32'h30;
  localparam logic [REG_W-1:0] OFS_PWR    = 32'h34;
  localparam logic [REG_W-1:0] OFS_BANK0  = 32'h40;
  localparam logic [REG_W-1:0] OFS_ECCCFG = 32'h94;
  localparam logic [REG_W-1:0] OFS_ECCERR = 32'h98;

  localparam logic [REG_W-1:0] MASK_CFG    = 32'hFFE00000;
  localparam logic [REG_W-1:0] MASK_RFR    = 32'h3FF80000;
  localparam logic [REG_W-1:0] MASK_PWR    = 32'hF8000000;
  localparam logic [REG_W-1:0] FORCE_PWR   = 32'h07C00000;
  localparam logic [REG_W-1:0] MASK_ECCCFG = 32'h00F00000;
  localparam logic [REG_W-1:0] MASK_ECCERR = 32'hFFF0F000;
  localparam logic [REG_W-1:0] MASK_BANK   = 32'hFFDEE001;

  localparam logic [REG_W-1:0] RST_CFG = 32'h00800000;
  localparam logic [REG_W-1:0] RST_RFR = 32'h05F00000;
  localparam logic [REG_W-1:0] RST_PWR = 32'h07C00000;

  localparam int CFG_ON_BIT   = 31;
  localparam int CFG_SELF_BIT = 30;

  typedef struct packed {
    logic                 esr0;
    logic                 esr1;
    logic                 eaddr;
    logic                 cfg;
    logic                 rfr;
    logic                 pwr;
    logic                 eccCfg;
    logic                 eccErr;
    logic [NUM_BANKS-1:0] bank;
  } wrStrobe_t;
endpackage

// File: rtl/sdram_cfg_ctrl.sv
module sdram_cfg_ctrl
  import sdram_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWe,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] pointer,
  output wrStrobe_t        strobe
);
  logic dataWr;

  always_ff @(posedge clk) begin
    if (!rstN)                 pointer <= '0;
    else if (busWe && !busSel) pointer <= busWdata;
  end

  assign dataWr = busWe && busSel;

  always_comb begin
    strobe        = '0;
    strobe.esr0   = dataWr && (pointer == OFS_ESR0);
    strobe.esr1   = dataWr && (pointer == OFS_ESR1);
    strobe.eaddr  = dataWr && (pointer == OFS_EADDR);
    strobe.cfg    = dataWr && (pointer == OFS_CFG);
    strobe.rfr    = dataWr && (pointer == OFS_RFR);
    strobe.pwr    = dataWr && (pointer == OFS_PWR);
    strobe.eccCfg = dataWr && (pointer == OFS_ECCCFG);
    strobe.eccErr = dataWr && (pointer == OFS_ECCERR);
    for (int b = 0; b < NUM_BANKS; b++) begin
      strobe.bank[b] = dataWr && (pointer == OFS_BANK0 + REG_W'(BANK_STRIDE * b));
    end
  end

  // R3: one offset selects at most one register
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
  // R1: the pointer holds its value when not written
  assert_pointer_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && !busSel) |=> $stable(pointer));
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  wrStrobe_t                       strobe,
  input  logic [REG_W-1:0]                wdata,
  input  logic [REG_W-1:0]                pointer,
  input  logic                            busSel,
  input  logic [REG_W-1:0]                errPulse0,
  input  logic [REG_W-1:0]                errPulse1,
  input  logic                            errAddrLoad,
  input  logic [REG_W-1:0]                errAddrIn,
  output logic [REG_W-1:0]                rdata,
  output logic                            cfgEnable,
  output logic [NUM_BANKS-1:0]            bankEn,
  output logic [NUM_BANKS-1:0][BASE_W-1:0] bankBase,
  output logic [NUM_BANKS-1:0][CODE_W-1:0] bankCode,
  output logic                            eccIrq
);
  logic [REG_W-1:0] esr0Reg, esr1Reg, eaddrReg, cfgReg, statReg;
  logic [REG_W-1:0] rfrReg, pwrReg, eccCfgReg, eccErrReg;
  logic [NUM_BANKS-1:0][REG_W-1:0] bankReg;
  logic [REG_W-1:0] cfgNext, dataRd;

  assign cfgNext = wdata & MASK_CFG;

  // error status: write-one-to-clear, hardware pulse has priority
  always_ff @(posedge clk) begin
    if (!rstN) begin
      esr0Reg <= '0;
      esr1Reg <= '0;
    end else begin
      esr0Reg <= (esr0Reg & ~(strobe.esr0 ? wdata : '0)) | errPulse0;
      esr1Reg <= (esr1Reg & ~(strobe.esr1 ? wdata : '0)) | errPulse1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            eaddrReg <= '0;
    else if (errAddrLoad) eaddrReg <= errAddrIn;
    else if (strobe.eaddr) eaddrReg <= wdata;
  end

  // configuration and the status bits it drives
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg  <= RST_CFG;
      statReg <= '0;
    end else if (strobe.cfg) begin
      cfgReg <= cfgNext;
      if (!cfgReg[CFG_ON_BIT] && cfgNext[CFG_ON_BIT])      statReg[CFG_ON_BIT] <= 1'b0;
      else if (cfgReg[CFG_ON_BIT] && !cfgNext[CFG_ON_BIT]) statReg[CFG_ON_BIT] <= 1'b1;
      statReg[CFG_SELF_BIT] <= cfgNext[CFG_SELF_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rfrReg    <= RST_RFR;
      pwrReg    <= RST_PWR;
      eccCfgReg <= '0;
      eccErrReg <= '0;
    end else begin
      if (strobe.rfr)    rfrReg    <= wdata & MASK_RFR;
      if (strobe.pwr)    pwrReg    <= (wdata & MASK_PWR) | FORCE_PWR;
      if (strobe.eccCfg) eccCfgReg <= wdata & MASK_ECCCFG;
      if (strobe.eccErr) eccErrReg <= wdata & MASK_ECCERR;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bankReg
    always_ff @(posedge clk) begin
      if (!rstN)               bankReg[b] <= '0;
      else if (strobe.bank[b]) bankReg[b] <= wdata & MASK_BANK;
    end
    assign bankEn[b]   = bankReg[b][0];
    assign bankBase[b] = bankReg[b][REG_W-1:BASE_LSB];
    assign bankCode[b] = bankReg[b][CODE_LSB +: CODE_W];
  end

  assign cfgEnable = cfgReg[CFG_ON_BIT];
  assign eccIrq    = |eccErrReg;

  always_comb begin
    dataRd = '1;
    if (pointer == OFS_ESR0)        dataRd = esr0Reg;
    else if (pointer == OFS_ESR1)   dataRd = esr1Reg;
    else if (pointer == OFS_EADDR)  dataRd = eaddrReg;
    else if (pointer == OFS_CFG)    dataRd = cfgReg;
    else if (pointer == OFS_STAT)   dataRd = statReg;
    else if (pointer == OFS_RFR)    dataRd = rfrReg;
    else if (pointer == OFS_PWR)    dataRd = pwrReg;
    else if (pointer == OFS_ECCCFG) dataRd = eccCfgReg;
    else if (pointer == OFS_ECCERR) dataRd = eccErrReg;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (pointer == OFS_BANK0 + REG_W'(BANK_STRIDE * b)) dataRd = bankReg[b];
    end
  end

  assign rdata = busSel ? dataRd : pointer;

  // R5: the forced power-management field never drops
  assert_pwr_forced_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pwrReg & FORCE_PWR) == FORCE_PWR);
  // R6: a hardware pulse is always captured, whatever the bus does
  assert_pulse_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (errPulse0 != '0) |=> ((esr0Reg & $past(errPulse0)) == $past(errPulse0)));
  // R8: enabling clears the disabled flag
  assert_enable_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgReg[CFG_ON_BIT]) |-> !statReg[CFG_ON_BIT]);
  // R8: disabling sets the disabled flag
  assert_disable_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgReg[CFG_ON_BIT]) |-> statReg[CFG_ON_BIT]);
  // R14: storing zero lowers the interrupt
  assert_irq_falls_R14: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eccErr && ((wdata & MASK_ECCERR) == '0)) |=> !eccIrq);
endmodule

// File: rtl/sdram_bank_decode.sv
module sdram_bank_decode
  import sdram_cfg_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cfgEnable,
  input  logic [NUM_BANKS-1:0]            bankEn,
  input  logic [NUM_BANKS-1:0][BASE_W-1:0] bankBase,
  input  logic [NUM_BANKS-1:0][CODE_W-1:0] bankCode,
  input  logic [REG_W-1:0]                sysAddr,
  output logic [NUM_BANKS-1:0]            bankHit,
  output logic [REG_W-1:0]                bankOffset
);
  localparam logic [REG_W-1:0] MIN_SPAN = REG_W'(1) << MIN_SPAN_LOG2;

  logic [NUM_BANKS-1:0]            candHit;
  logic [NUM_BANKS-1:0][REG_W-1:0] candOfs;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
    logic [REG_W-1:0] baseAddr, span, diff;
    assign baseAddr   = {bankBase[b], {BASE_LSB{1'b0}}};
    assign span       = MIN_SPAN << bankCode[b];
    assign diff       = sysAddr - baseAddr;
    assign candHit[b] = cfgEnable && bankEn[b] && (bankCode[b] != INVALID_CODE)
                        && (sysAddr >= baseAddr) && (diff < span);
    assign candOfs[b] = diff;
  end

  // lowest index wins: scan from the top so the lowest overwrites last
  always_comb begin
    bankHit    = '0;
    bankOffset = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (candHit[b]) begin
        bankHit    = '0;
        bankHit[b] = 1'b1;
        bankOffset = candOfs[b];
      end
    end
  end

  // R13: never more than one bank reported
  assert_hit_onehot_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankHit));
  // R12: a disabled controller decodes nothing
  assert_gated_R12: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> (bankHit == '0));
  // R12: a miss carries a zero offset
  assert_miss_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (bankHit == '0) |-> (bankOffset == '0));
endmodule

// File: rtl/sdram_cfg_unit.sv
module sdram_cfg_unit
  import sdram_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWe,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic [31:0] errPulse0,
  input  logic [31:0] errPulse1,
  input  logic        errAddrLoad,
  input  logic [31:0] errAddrIn,
  input  logic [31:0] sysAddr,
  output logic [3:0]  bankHit,
  output logic [31:0] bankOffset,
  output logic        eccIrq
);
  logic [REG_W-1:0]                pointer;
  wrStrobe_t                       strobe;
  logic                            cfgEnable;
  logic [NUM_BANKS-1:0]            bankEn;
  logic [NUM_BANKS-1:0][BASE_W-1:0] bankBase;
  logic [NUM_BANKS-1:0][CODE_W-1:0] bankCode;

  sdram_cfg_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWe    (busWe),
    .busWdata (busWdata),
    .pointer  (pointer),
    .strobe   (strobe)
  );

  sdram_cfg_regs i_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wdata       (busWdata),
    .pointer     (pointer),
    .busSel      (busSel),
    .errPulse0   (errPulse0),
    .errPulse1   (errPulse1),
    .errAddrLoad (errAddrLoad),
    .errAddrIn   (errAddrIn),
    .rdata       (busRdata),
    .cfgEnable   (cfgEnable),
    .bankEn      (bankEn),
    .bankBase    (bankBase),
    .bankCode    (bankCode),
    .eccIrq      (eccIrq)
  );

  sdram_bank_decode i_decode (
    .clk        (clk),
    .rstN       (rstN),
    .cfgEnable  (cfgEnable),
    .bankEn     (bankEn),
    .bankBase   (bankBase),
    .bankCode   (bankCode),
    .sysAddr    (sysAddr),
    .bankHit    (bankHit),
    .bankOffset (bankOffset)
  );
endmodule

// File: tb/test_sdram_cfg_unit.sv
module test_sdram_cfg_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] errPulse0 = '0;
  logic [31:0] errPulse1 = '0;
  logic        errAddrLoad = 1'b0;
  logic [31:0] errAddrIn = '0;
  logic [31:0] sysAddr = '0;
  logic [3:0]  bankHit;
  logic [31:0] bankOffset;
  logic        eccIrq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sdram_cfg_unit i_sdram_cfg_unit (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata),
    .errPulse0(errPulse0), .errPulse1(errPulse1),
    .errAddrLoad(errAddrLoad), .errAddrIn(errAddrIn),
    .sysAddr(sysAddr), .bankHit(bankHit), .bankOffset(bankOffset),
    .eccIrq(eccIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic sel, input logic [31:0] d);
    @(negedge clk);
    busSel = sel; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic regWrite(input logic [31:0] ofs, input logic [31:0] d);
    busWrite(1'b0, ofs);
    busWrite(1'b1, d);
  endtask

  task automatic regRead(input logic [31:0] ofs, output logic [31:0] v);
    busWrite(1'b0, ofs);
    busSel = 1'b1;
    #1 v = busRdata;
  endtask

  task automatic expectReg(input string tag, input logic [31:0] ofs, input logic [31:0] exp);
    logic [31:0] v;
    regRead(ofs, v);
    check(tag, v, exp);
  endtask

  task automatic probe(input string tag, input logic [31:0] a,
                       input logic [3:0] expHit, input logic [31:0] expOfs);
    @(negedge clk);
    sysAddr = a;
    #1;
    check({tag, " hit"}, {28'h0, bankHit}, {28'h0, expHit});
    check({tag, " offset"}, bankOffset, expOfs);
  endtask

  task automatic clearBanks();
    for (int b = 0; b < 4; b++) regWrite(32'h40 + 32'(4 * b), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] pats [5];
    logic [31:0] v;
    pats[0] = 32'hFFFFFFFF; pats[1] = 32'h00000000; pats[2] = 32'hA5A5A5A5;
    pats[3] = 32'h5A5A5A5A; pats[4] = 32'h12345678;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 and R2: reset state
    busSel = 1'b0; #1;
    check("R1 pointer reset", busRdata, 32'h0);
    check("R14 irq reset", {31'h0, eccIrq}, 32'h0);
    check("R12 hit reset", {28'h0, bankHit}, 32'h0);
    expectReg("R2 esr0", 32'h00, 32'h0);
    expectReg("R2 esr1", 32'h08, 32'h0);
    expectReg("R2 eaddr", 32'h10, 32'h0);
    expectReg("R2 cfg", 32'h20, 32'h00800000);
    expectReg("R2 status", 32'h24, 32'h0);
    expectReg("R2 refresh", 32'h30, 32'h05F00000);
    expectReg("R2 pwr", 32'h34, 32'h07C00000);
    for (int b = 0; b < 4; b++) expectReg("R2 bank", 32'h40 + 32'(4 * b), 32'h0);
    expectReg("R2 ecccfg", 32'h94, 32'h0);
    expectReg("R2 eccerr", 32'h98, 32'h0);

    // R1: pointer readback
    for (int i = 0; i < 5; i++) begin
      busWrite(1'b0, pats[i]);
      busSel = 1'b0; #1;
      check("R1 pointer readback", busRdata, pats[i]);
    end

    // R3: timing and unknown offsets read all ones, status and unknown ignore writes
    expectReg("R3 timing", 32'h80, 32'hFFFFFFFF);
    for (int i = 0; i < 6; i++) begin
      logic [31:0] ofs;
      ofs = (i == 0) ? 32'h04 : (i == 1) ? 32'h0C : (i == 2) ? 32'h50 :
            (i == 3) ? 32'h84 : (i == 4) ? 32'h9C : 32'h100;
      regWrite(ofs, 32'hFFFFFFFF);
      expectReg("R3 unknown", ofs, 32'hFFFFFFFF);
    end
    regWrite(32'h24, 32'hFFFFFFFF);
    expectReg("R3 status write ignored", 32'h24, 32'h0);
    expectReg("R3 cfg untouched", 32'h20, 32'h00800000);
    expectReg("R3 eccerr untouched", 32'h98, 32'h0);
    check("R3 irq untouched", {31'h0, eccIrq}, 32'h0);

    // R4, R5: masks
    for (int i = 0; i < 5; i++) begin
      regWrite(32'h20, pats[i]);
      expectReg("R4 cfg mask", 32'h20, pats[i] & 32'hFFE00000);
      regWrite(32'h30, pats[i]);
      expectReg("R4 refresh mask", 32'h30, pats[i] & 32'h3FF80000);
      regWrite(32'h94, pats[i]);
      expectReg("R4 ecccfg mask", 32'h94, pats[i] & 32'h00F00000);
      regWrite(32'h98, pats[i]);
      expectReg("R4 eccerr mask", 32'h98, pats[i] & 32'hFFF0F000);
      regWrite(32'h34, pats[i]);
      expectReg("R5 pwr force", 32'h34, (pats[i] & 32'hF8000000) | 32'h07C00000);
    end
    regWrite(32'h98, 32'h0);
    regWrite(32'h20, 32'h0);

    // R8, R9: enable sequencing
    regWrite(32'h20, 32'h80000000);
    expectReg("R8 enable clears", 32'h24, 32'h00000000);
    regWrite(32'h20, 32'h00000000);
    expectReg("R8 disable sets", 32'h24, 32'h80000000);
    regWrite(32'h20, 32'h40000000);
    expectReg("R9 bit30 follows, R8 bit31 held", 32'h24, 32'hC0000000);
    regWrite(32'h20, 32'hC0000000);
    expectReg("R8 enable with bit30", 32'h24, 32'h40000000);
    regWrite(32'h20, 32'h80000000);
    expectReg("R9 bit30 cleared", 32'h24, 32'h00000000);
    regWrite(32'h20, 32'h80000000);
    expectReg("R8 unchanged write", 32'h24, 32'h00000000);
    regWrite(32'h20, 32'h0);

    // R6: error status
    @(negedge clk); errPulse0 = 32'h0000F00F; errPulse1 = 32'h80000001;
    @(negedge clk); errPulse0 = '0; errPulse1 = '0;
    expectReg("R6 esr0 set", 32'h00, 32'h0000F00F);
    expectReg("R6 esr1 set", 32'h08, 32'h80000001);
    regWrite(32'h00, 32'h0000000F);
    expectReg("R6 esr0 w1c", 32'h00, 32'h0000F000);
    regWrite(32'h08, 32'h80000000);
    expectReg("R6 esr1 w1c", 32'h08, 32'h00000001);
    busWrite(1'b0, 32'h00);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busWdata = 32'h0000F001; errPulse0 = 32'h00000001;
    @(negedge clk);
    busWe = 1'b0; errPulse0 = '0;
    expectReg("R6 pulse beats clear", 32'h00, 32'h00000001);

    // R7: error address
    @(negedge clk); errAddrLoad = 1'b1; errAddrIn = 32'h12345678;
    @(negedge clk); errAddrLoad = 1'b0;
    expectReg("R7 hw load", 32'h10, 32'h12345678);
    regWrite(32'h10, 32'hAAAA0000);
    expectReg("R7 bus load", 32'h10, 32'hAAAA0000);
    busWrite(1'b0, 32'h10);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busWdata = 32'h55555555;
    errAddrLoad = 1'b1; errAddrIn = 32'hCAFE0000;
    @(negedge clk);
    busWe = 1'b0; errAddrLoad = 1'b0;
    expectReg("R7 hw wins", 32'h10, 32'hCAFE0000);

    // R10: bank masks
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 5; i++) begin
        regWrite(32'h40 + 32'(4 * b), pats[i]);
        expectReg("R10 bank mask", 32'h40 + 32'(4 * b), pats[i] & 32'hFFDEE001);
      end
    clearBanks();

    // R11: decode sweep, one bank at a time, every code
    regWrite(32'h20, 32'h80000000);
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 8; c++) begin
        logic [31:0] base, span;
        logic [3:0]  h;
        base = 32'h20000000 + 32'(b) * 32'h08000000;
        span = 32'h00400000 << c;
        h = (c == 7) ? 4'h0 : 4'(1 << b);
        clearBanks();
        regWrite(32'h40 + 32'(4 * b), base | (32'(c) << 17) | 32'h1);
        probe("R11 below base", base - 1, 4'h0, 32'h0);
        probe("R11 at base", base, h, (c == 7) ? 32'h0 : 32'h0);
        probe("R11 middle", base + span / 2, h, (c == 7) ? 32'h0 : span / 2);
        probe("R11 last", base + span - 1, h, (c == 7) ? 32'h0 : span - 1);
        probe("R11 past end", base + span, 4'h0, 32'h0);
      end

    // R12: gating
    clearBanks();
    regWrite(32'h40, 32'h00040001);
    probe("R12 enabled", 32'h00000100, 4'h1, 32'h100);
    regWrite(32'h20, 32'h0);
    probe("R12 controller off", 32'h00000100, 4'h0, 32'h0);
    regWrite(32'h20, 32'h80000000);
    regWrite(32'h40, 32'h00040000);
    probe("R12 bank off", 32'h00000100, 4'h0, 32'h0);

    // R13: overlap priority
    regWrite(32'h40, 32'h08000001);
    regWrite(32'h44, 32'h08060001);
    regWrite(32'h48, 32'h000C0001);
    probe("R13 bank0 wins", 32'h08000010, 4'h1, 32'h10);
    probe("R13 bank1 wins", 32'h08500000, 4'h2, 32'h00500000);
    probe("R13 bank2 only", 32'h0A000000, 4'h4, 32'h0A000000);
    regWrite(32'h20, 32'h0);

    // R14: ECC interrupt
    regWrite(32'h98, 32'h00010000);
    check("R14 masked bit no irq", {31'h0, eccIrq}, 32'h0);
    regWrite(32'h98, 32'h00001000);
    check("R14 irq rises", {31'h0, eccIrq}, 32'h1);
    regWrite(32'h98, 32'h0);
    check("R14 irq falls", {31'h0, eccIrq}, 32'h0);
    regWrite(32'h98, 32'h80000000);
    check("R14 irq rises top", {31'h0, eccIrq}, 32'h1);
    regWrite(32'h98, 32'h00040000);
    check("R14 masked write clears", {31'h0, eccIrq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule